// File: doc/BRIEF.md
# SDRAM Open-Row Bank Manager

This block sits between an access requester and the SDRAM command bus and keeps one row open per bank for as long as it is useful. Each request names a bank, a row and a direction. The block looks the bank up in its own table of open rows and decides which command the access needs. A request for the row that is already open becomes a read or write at once. A request to an idle bank first gets an activate. A request for some other row in an open bank first gets a precharge and then an activate. The block issues at most one command per cycle. It accepts the request only in the cycle that it commits the read or write.

Rows are left open through idle gaps, so a later access to the same row costs no activate. A row is closed in only three cases: the next access in that bank wants another row, a refresh is pending, or the row has been open for nearly the maximum row-active time. While a refresh is pending, all requests are held. The open banks are closed with a single precharge-all. The block then signals that the refresh may go ahead once the precharge recovery time has passed. The refresh command itself and its timing belong to the surrounding controller. Command spacing (activate to access, precharge to activate, minimum row-active time) is set by parameters.

Top module: `sdram_row_tracker`

## Requirements
- R1: After reset, no bank is open, `cmdCode` is NOP (0), and `reqReady` and `refreshGo` are low.
- R2: A request to a bank with no open row produces an activate (code 1) that carries the request's bank and row. The read (code 2) or write (code 3) to that bank follows no sooner than T_RCD cycles after the activate.
- R3: A request whose bank has the requested row open is accepted (`reqReady` high) in the cycle its read or write is decided. That command appears on `cmdCode` and `cmdBank` in the following cycle, with no activate or precharge before it.
- R4: A request to a bank that has a different row open produces a precharge (code 4) to that bank, then an activate of the new row, then the access. The precharge comes at least T_RAS_MIN cycles after the earlier activate, and the activate comes at least T_RP cycles after the precharge.
- R5: An open row stays open while no requests arrive: no command is issued during the gap, and a later request for the same row gets only its read or write.
- R6: While `refreshPending` is high, no request is accepted. If any bank is open, a single precharge-all (code 5) closes them all. `refreshGo` goes high exactly T_RP-1 cycles after the cycle that shows the precharge-all, and only while `refreshPending` is high.
- R7: A row left open with no other command to its bank is precharged automatically. The precharge appears exactly T_RAS_MAX-CLOSE_MARGIN+1 cycles after its activate, and a later request to that bank then needs a new activate.
- R8: The four banks are tracked independently. Rows may be open in all four at once, and each later request that hits its bank's open row gets only a read or write.
- R9: `cmdCode` only takes the values 0 to 5. Every non-NOP command corresponds to one required step, with no extra or missing commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | An access request is present |
| reqReady | output | 1 | Request accepted this cycle (its read or write is being issued) |
| reqBank | input | 2 | Bank of the request |
| reqRow | input | ROW_W | Row of the request |
| reqWrite | input | 1 | 1 for write, 0 for read |
| refreshPending | input | 1 | A refresh is due; close all rows and hold requests |
| refreshGo | output | 1 | All banks closed and precharge recovery met; refresh may be issued |
| cmdCode | output | 3 | Command: 0 NOP, 1 activate, 2 read, 3 write, 4 precharge bank, 5 precharge all |
| cmdBank | output | 2 | Bank the command addresses |
| cmdRow | output | ROW_W | Row for an activate |

## Verification
The hardest case to reach from the ports is the automatic close near the maximum row-active time. It only happens when a bank has been left open and untouched for dozens of cycles. Every ordinary access sequence either closes the row sooner or keeps the bus busy. The bench therefore opens a row, goes quiet, and measures the exact distance between the activate and the self-generated precharge. Before the quiet gap, the activate and its access are queued as expected items. A second hard case is a hit request held steady while a refresh is pending. The bench holds that request across the whole precharge-all and recovery window, and checks that it is refused until the refresh request drops and then becomes a fresh activate.

// File: rtl/sdram_row_pkg.sv
package sdram_row_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W = $clog2(NUM_BANKS);

  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_ACT    = 3'd1,
    CMD_RD     = 3'd2,
    CMD_WR     = 3'd3,
    CMD_PRE    = 3'd4,
    CMD_PREALL = 3'd5
  } cmd_e;

  // strobes from control to the bank table
  typedef struct packed {
    logic              act;
    logic              pre;
    logic              preAll;
    logic [BANK_W-1:0] bank;
  } bankStrobe_t;
endpackage

// File: rtl/sdram_row_table.sv
module sdram_row_table
  import sdram_row_pkg::*;
#(
  parameter int ROW_W        = 13,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 3,
  parameter int T_RAS_MIN    = 6,
  parameter int T_RAS_MAX    = 7000,
  parameter int CLOSE_MARGIN = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bankStrobe_t          stb,
  input  logic [ROW_W-1:0]     actRow,
  input  logic [ROW_W-1:0]     lookupRow,
  output logic [NUM_BANKS-1:0] openVec,
  output logic [NUM_BANKS-1:0] rowMatch,
  output logic [NUM_BANKS-1:0] rcdOk,
  output logic [NUM_BANKS-1:0] rpOk,
  output logic [NUM_BANKS-1:0] rasMinOk,
  output logic [NUM_BANKS-1:0] forceVec
);
  localparam int GAP_MAX  = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int GAP_W    = $clog2(GAP_MAX + 1);
  localparam int RAS_W    = $clog2(T_RAS_MAX + 1);
  localparam int FORCE_AT = T_RAS_MAX - CLOSE_MARGIN;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             valid;
    logic [ROW_W-1:0] row;
    logic [GAP_W-1:0] gapCnt;  // activate-to-access or precharge-to-activate wait
    logic [RAS_W-1:0] rasCnt;  // cycles since activate
    logic             selAct;
    logic             selPre;

    assign selAct = stb.act && (stb.bank == BANK_W'(b));
    assign selPre = (stb.pre && (stb.bank == BANK_W'(b))) || stb.preAll;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        valid  <= 1'b0;
        row    <= '0;
        gapCnt <= '0;
        rasCnt <= '0;
      end else if (selAct) begin
        valid  <= 1'b1;
        row    <= actRow;
        gapCnt <= GAP_W'(T_RCD);
        rasCnt <= '0;
      end else if (selPre) begin
        valid  <= 1'b0;
        gapCnt <= GAP_W'(T_RP);
        rasCnt <= '0;
      end else begin
        if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
        if (valid && (rasCnt != RAS_W'(T_RAS_MAX))) rasCnt <= rasCnt + 1'b1;
      end
    end

    // a command decided now shows one cycle later, hence the "<= 1" and "-1"
    assign openVec[b]  = valid;
    assign rowMatch[b] = (row == lookupRow);
    assign rcdOk[b]    = valid && (gapCnt <= GAP_W'(1));
    assign rpOk[b]     = !valid && (gapCnt <= GAP_W'(1));
    assign rasMinOk[b] = valid && (rasCnt >= RAS_W'(T_RAS_MIN - 1));
    assign forceVec[b] = valid && (rasCnt >= RAS_W'(FORCE_AT));
  end
endmodule

// File: rtl/sdram_row_ctrl.sv
module sdram_row_ctrl
  import sdram_row_pkg::*;
#(
  parameter int ROW_W = 13
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [ROW_W-1:0]     reqRow,
  input  logic                 reqWrite,
  input  logic                 refreshPending,
  input  logic [NUM_BANKS-1:0] openVec,
  input  logic [NUM_BANKS-1:0] rowMatch,
  input  logic [NUM_BANKS-1:0] rcdOk,
  input  logic [NUM_BANKS-1:0] rpOk,
  input  logic [NUM_BANKS-1:0] rasMinOk,
  input  logic [NUM_BANKS-1:0] forceVec,
  output bankStrobe_t          stb,
  output logic                 reqReady,
  output logic                 refreshGo,
  output cmd_e                 cmdCode,
  output logic [BANK_W-1:0]    cmdBank,
  output logic [ROW_W-1:0]     cmdRow
);
  cmd_e              nextCode;
  logic [BANK_W-1:0] nextBank;
  logic              forceFound;
  logic [BANK_W-1:0] forceBank;

  always_comb begin
    forceFound = 1'b0;
    forceBank  = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (forceVec[i]) begin
        forceFound = 1'b1;
        forceBank  = BANK_W'(i);
      end
    end
  end

  always_comb begin
    stb       = '0;
    nextCode  = CMD_NOP;
    nextBank  = reqBank;
    reqReady  = 1'b0;
    refreshGo = 1'b0;
    if (forceFound) begin
      stb.pre  = 1'b1;
      stb.bank = forceBank;
      nextCode = CMD_PRE;
      nextBank = forceBank;
    end else if (refreshPending) begin
      nextBank = '0;
      if (|openVec) begin
        if (&(~openVec | rasMinOk)) begin
          stb.preAll = 1'b1;
          nextCode   = CMD_PREALL;
        end
      end else begin
        refreshGo = &rpOk;
      end
    end else if (reqValid) begin
      stb.bank = reqBank;
      if (openVec[reqBank] && rowMatch[reqBank]) begin
        if (rcdOk[reqBank]) begin
          reqReady = 1'b1;
          nextCode = reqWrite ? CMD_WR : CMD_RD;
        end
      end else if (openVec[reqBank]) begin
        if (rasMinOk[reqBank]) begin
          stb.pre  = 1'b1;
          nextCode = CMD_PRE;
        end
      end else if (rpOk[reqBank]) begin
        stb.act  = 1'b1;
        nextCode = CMD_ACT;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdCode <= CMD_NOP;
      cmdBank <= '0;
      cmdRow  <= '0;
    end else begin
      cmdCode <= nextCode;
      cmdBank <= nextBank;
      cmdRow  <= reqRow;
    end
  end
endmodule

// File: rtl/sdram_row_tracker.sv
module sdram_row_tracker
  import sdram_row_pkg::*;
#(
  parameter int ROW_W        = 13,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 3,
  parameter int T_RAS_MIN    = 6,
  parameter int T_RAS_MAX    = 7000,
  parameter int CLOSE_MARGIN = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqBank,
  input  logic [ROW_W-1:0] reqRow,
  input  logic             reqWrite,
  input  logic             refreshPending,
  output logic             refreshGo,
  output logic [2:0]       cmdCode,
  output logic [1:0]       cmdBank,
  output logic [ROW_W-1:0] cmdRow
);
  bankStrobe_t          stb;
  logic [NUM_BANKS-1:0] openVec, rowMatch, rcdOk, rpOk, rasMinOk, forceVec;
  cmd_e                 cmdEnum;

  sdram_row_table #(
    .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN),
    .T_RAS_MAX(T_RAS_MAX), .CLOSE_MARGIN(CLOSE_MARGIN)
  ) u_table (
    .clk(clk), .rstN(rstN), .stb(stb), .actRow(reqRow), .lookupRow(reqRow),
    .openVec(openVec), .rowMatch(rowMatch), .rcdOk(rcdOk), .rpOk(rpOk),
    .rasMinOk(rasMinOk), .forceVec(forceVec)
  );

  sdram_row_ctrl #(.ROW_W(ROW_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBank(reqBank), .reqRow(reqRow),
    .reqWrite(reqWrite), .refreshPending(refreshPending), .openVec(openVec),
    .rowMatch(rowMatch), .rcdOk(rcdOk), .rpOk(rpOk), .rasMinOk(rasMinOk),
    .forceVec(forceVec), .stb(stb), .reqReady(reqReady), .refreshGo(refreshGo),
    .cmdCode(cmdEnum), .cmdBank(cmdBank), .cmdRow(cmdRow)
  );

  assign cmdCode = cmdEnum;
endmodule

// File: rtl/sdram_row_tracker_chk.sv
module sdram_row_tracker_chk #(
  parameter int ROW_W     = 13,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS_MIN = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [1:0]       reqBank,
  input logic [ROW_W-1:0] reqRow,
  input logic             refreshPending,
  input logic             refreshGo,
  input logic [2:0]       cmdCode,
  input logic [1:0]       cmdBank
);
  // R3
  hit_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> ((cmdCode == 3'd2 || cmdCode == 3'd3) && cmdBank == $past(reqBank)));

  // R6
  refresh_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshPending |-> !reqReady);

  // R6
  go_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    refreshGo |-> refreshPending);

  // R9
  legal_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode <= 3'd5);

  if (T_RCD > 1) begin : g_rcd
    // R2
    act_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cmdCode == 3'd1) |=> !((cmdCode == 3'd2 || cmdCode == 3'd3) && cmdBank == $past(cmdBank)));
  end

  if (T_RP > 1) begin : g_rp
    // R4
    pre_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cmdCode == 3'd4) |=> !(cmdCode == 3'd1 && cmdBank == $past(cmdBank)));
  end

  if (T_RAS_MIN > 1) begin : g_ras
    // R4
    ras_min_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cmdCode == 3'd1) |=> !(cmdCode == 3'd4 && cmdBank == $past(cmdBank)));
  end

  logic unusedRow;
  assign unusedRow = ^reqRow;
endmodule

bind sdram_row_tracker sdram_row_tracker_chk #(
  .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqBank(reqBank), .reqRow(reqRow), .refreshPending(refreshPending),
  .refreshGo(refreshGo), .cmdCode(cmdCode), .cmdBank(cmdBank)
);

// File: tb/sdram_row_tracker_test.sv
module sdram_row_tracker_test;
  localparam int CLK_PERIOD   = 10;
  localparam int ROW_W        = 13;
  localparam int T_RCD        = 3;
  localparam int T_RP         = 3;
  localparam int T_RAS_MIN    = 6;
  localparam int T_RAS_MAX    = 60;
  localparam int CLOSE_MARGIN = 8;
  localparam int FORCE_GAP    = T_RAS_MAX - CLOSE_MARGIN + 1;
  localparam int WATCHDOG     = 20000;

  typedef struct {
    int    code;
    int    bank;
    int    row;
    bit    forced;
    string req;
  } expItem_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic             reqReady;
  logic [1:0]       reqBank = '0;
  logic [ROW_W-1:0] reqRow = '0;
  logic             reqWrite = 1'b0;
  logic             refreshPending = 1'b0;
  logic             refreshGo;
  logic [2:0]       cmdCode;
  logic [1:0]       cmdBank;
  logic [ROW_W-1:0] cmdRow;

  int       testsRun = 0;
  int       testsFailed = 0;
  int       cyc = 0;
  bit       finished = 0;
  expItem_t expQ[$];
  bit       mOpen[4];
  int       mRow[4];
  int       lastAct[4];
  int       lastPre[4];
  int       preAllCyc = 0;

  sdram_row_tracker #(
    .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN),
    .T_RAS_MAX(T_RAS_MAX), .CLOSE_MARGIN(CLOSE_MARGIN)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqBank(reqBank), .reqRow(reqRow), .reqWrite(reqWrite),
    .refreshPending(refreshPending), .refreshGo(refreshGo),
    .cmdCode(cmdCode), .cmdBank(cmdBank), .cmdRow(cmdRow)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void push(input int code, input int bank, input int row, input bit forced, input string req);
    expItem_t it;
    it.code = code; it.bank = bank; it.row = row; it.forced = forced; it.req = req;
    expQ.push_back(it);
  endfunction

  // monitor: pops the scoreboard for every command seen on the bus
  always @(negedge clk) begin
    if (rstN && cmdCode != 3'd0) begin
      if (expQ.size() == 0) begin
        check(0, "R9", "unexpected command", int'(cmdCode), 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(int'(cmdCode) == it.code, it.req, "command code", int'(cmdCode), it.code);
        if (it.code != 5)
          check(int'(cmdBank) == it.bank, it.req, "command bank", int'(cmdBank), it.bank);
        if (it.code == 1)
          check(int'(cmdRow) == it.row, "R2", "activate row", int'(cmdRow), it.row);
        case (cmdCode)
          3'd1: begin
            check(cyc - lastPre[cmdBank] >= T_RP, "R4", "precharge-to-activate gap", cyc - lastPre[cmdBank], T_RP);
            lastAct[cmdBank] = cyc;
          end
          3'd2, 3'd3:
            check(cyc - lastAct[cmdBank] >= T_RCD, "R2", "activate-to-access gap", cyc - lastAct[cmdBank], T_RCD);
          3'd4: begin
            check(cyc - lastAct[cmdBank] >= T_RAS_MIN, "R4", "row-active minimum", cyc - lastAct[cmdBank], T_RAS_MIN);
            if (it.forced)
              check(cyc - lastAct[cmdBank] == FORCE_GAP, "R7", "forced close distance", cyc - lastAct[cmdBank], FORCE_GAP);
            lastPre[cmdBank] = cyc;
          end
          3'd5: begin
            for (int b = 0; b < 4; b++) lastPre[b] = cyc;
            preAllCyc = cyc;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic doReset();
    rstN = 1'b0;
    reqValid = 1'b0;
    refreshPending = 1'b0;
    expQ.delete();
    for (int b = 0; b < 4; b++) begin
      mOpen[b] = 0; mRow[b] = 0; lastAct[b] = -1000; lastPre[b] = -1000;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(cmdCode == 3'd0, "R1", "cmdCode after reset", int'(cmdCode), 0);
    check(!reqReady, "R1", "reqReady after reset", int'(reqReady), 0);
    check(!refreshGo, "R1", "refreshGo after reset", int'(refreshGo), 0);
  endtask

  task automatic doReq(input int b, input int row, input bit wr, input string req);
    int waitCnt;
    if (mOpen[b] && mRow[b] == row) begin
      push(wr ? 3 : 2, b, row, 0, req);
    end else begin
      if (mOpen[b]) push(4, b, 0, 0, "R4");
      push(1, b, row, 0, req);
      push(wr ? 3 : 2, b, row, 0, req);
      mOpen[b] = 1;
      mRow[b] = row;
    end
    @(negedge clk);
    reqValid = 1'b1; reqBank = 2'(b); reqRow = ROW_W'(row); reqWrite = wr;
    waitCnt = 0;
    forever begin
      #1;
      if (reqReady || waitCnt > 50) break;
      @(negedge clk);
      waitCnt++;
    end
    check(waitCnt <= 50, req, "request accepted", waitCnt, 50);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic drain(input string req);
    int waitCnt = 0;
    while (expQ.size() != 0 && waitCnt < 200) begin
      @(negedge clk);
      waitCnt++;
    end
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, req, "missing commands", expQ.size(), 0);
  endtask

  initial begin
    doReset();

    // R2, R3, R5: activate on idle bank, hits, idle gap keeps the row open
    doReq(0, 5, 0, "R2");
    doReq(0, 5, 1, "R3");
    drain("R3");
    repeat (20) @(negedge clk);
    doReq(0, 5, 0, "R5");
    drain("R5");

    // R4: row miss in an open bank
    doReset();
    doReq(1, 100, 1, "R2");
    doReq(1, 200, 0, "R4");
    doReq(1, 300, 1, "R4");
    drain("R4");

    // R8: all four banks open together
    doReset();
    for (int b = 0; b < 4; b++) doReq(b, 10 + b, b[0], "R8");
    for (int b = 3; b >= 0; b--) doReq(b, 10 + b, 1'b0, "R8");
    drain("R8");

    // R6: refresh closes everything and holds a hit request
    doReset();
    doReq(0, 3, 0, "R6");
    doReq(2, 11, 1, "R6");
    drain("R6");
    begin
      int  goCyc = -1;
      bit  badAccept = 0;
      push(5, 0, 0, 0, "R6");
      push(1, 0, 3, 0, "R6");
      push(2, 0, 3, 0, "R6");
      for (int b = 0; b < 4; b++) mOpen[b] = 0;
      mOpen[0] = 1; mRow[0] = 3;
      @(negedge clk);
      refreshPending = 1'b1;
      reqValid = 1'b1; reqBank = 2'd0; reqRow = ROW_W'(3); reqWrite = 1'b0;
      for (int i = 0; i < 30; i++) begin
        #1;
        if (reqReady) badAccept = 1;
        if (refreshGo && goCyc < 0) goCyc = cyc;
        @(negedge clk);
      end
      check(!badAccept, "R6", "request accepted during refresh", int'(badAccept), 0);
      check(goCyc - preAllCyc == T_RP - 1, "R6", "refreshGo delay", goCyc - preAllCyc, T_RP - 1);
      refreshPending = 1'b0;
      for (int i = 0; i < 30; i++) begin
        #1;
        if (reqReady) break;
        @(negedge clk);
      end
      @(negedge clk);
      reqValid = 1'b0;
      #1;
      check(!refreshGo, "R6", "refreshGo without pending", int'(refreshGo), 0);
      drain("R6");
    end

    // R7: row left idle is closed before the row-active limit
    doReset();
    doReq(1, 7, 0, "R7");
    push(4, 1, 0, 1, "R7");
    mOpen[1] = 0;
    repeat (FORCE_GAP + 10) @(negedge clk);
    check(expQ.size() == 0, "R7", "forced precharge missing", expQ.size(), 0);
    doReq(1, 7, 1, "R7");
    drain("R7");

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule